// File: doc/BRIEF.md
# Register Rename Unit with Undo Log

This block turns architectural register names into physical ones for an out-of-order core. It holds a map from each architectural register to a physical one, a pool of unused physical registers, and an ordered undo log. Each cycle a group of up to `RN_WIDTH` instruction slots is offered. Every slot carries a sequence number, two source names and an optional destination. Sources are translated through the map. Each destination is given a fresh physical register, and a log entry records the sequence number, the architectural name, the new register and the register it displaced.

When an instruction commits, its log entry is retired and the displaced register goes back to the pool. A squash names a sequence number. The unit then works backward through the log, one entry per cycle, from the youngest entry. Each entry it reaches puts the displaced mapping back into the map and returns the new register to the pool. The walk stops at the first entry that is not younger than the squash point. While the walk runs, renaming is held off.

Top module: `rn_rename`

## Requirements
- R1: After a synchronous reset, architectural register r maps to physical register r, physical registers NUM_ARCH..NUM_PHYS-1 are free, `in_ready` is 1, `busy` is 0 and `out_valid` is 0.
- R2: For each slot of an accepted group, the cycle after acceptance, `out_valid`, `out_seq` and both source tags show the slot's validity, its sequence number and the current physical mapping of each source (slot i occupies bits [i*W +: W] of each packed field).
- R3: Each accepted destination takes the lowest-numbered free physical register. Lower-numbered slots are served first. The result appears on `out_dst_p` one cycle after acceptance.
- R4: Within one group, a source or destination that names the destination of an earlier slot in the same group sees that slot's newly allocated register. When several earlier slots write the same name, the latest of them applies.
- R5: `in_ready` is 0 when the free pool holds fewer registers than the group has destinations. A group offered while `in_ready` is 0 is dropped: no output in the next cycle and no change to the map or the pool.
- R6: A valid slot with `in_has_dst`=0 allocates nothing and makes no log entry. Its `out_has_dst` is 0.
- R7: A commit retires the oldest log entry only when that entry's sequence number equals `commit_seq`, and returns its displaced register to the pool. Any other commit has no effect.
- R8: A squash raises `busy` from the next cycle. While a squash is offered or `busy` is 1, `in_ready` is 0. The walk undoes one entry per cycle, youngest first, while the entry's sequence number is greater than the squash point. `busy` falls in the cycle after the first entry that does not qualify, or after the log becomes empty.
- R9: Once the walk finishes, every architectural register renamed by an undone entry maps again to the register it had before that entry.
- R10: A register returned to the pool by commit or by a squash walk can be allocated from the following cycle. The number of free registers plus the number of log entries always equals NUM_PHYS-NUM_ARCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | RN_WIDTH | Slot valid bits of the offered group |
| in_has_dst | input | RN_WIDTH | Slot has a destination register |
| in_dst | input | RN_WIDTH*AW | Destination architectural names |
| in_src_a | input | RN_WIDTH*AW | First source architectural names |
| in_src_b | input | RN_WIDTH*AW | Second source architectural names |
| in_seq | input | RN_WIDTH*SEQ_W | Sequence numbers, increasing with program order |
| in_ready | output | 1 | Group is accepted this cycle |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Sequence number of the committing instruction |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash point: entries younger than this are undone |
| busy | output | 1 | Squash walk in progress |
| out_valid | output | RN_WIDTH | Renamed slot valid |
| out_has_dst | output | RN_WIDTH | Renamed slot carries a destination |
| out_seq | output | RN_WIDTH*SEQ_W | Sequence numbers of renamed slots |
| out_src_a_p | output | RN_WIDTH*PW | Physical tag of first source |
| out_src_b_p | output | RN_WIDTH*PW | Physical tag of second source |
| out_dst_p | output | RN_WIDTH*PW | Newly allocated physical destination |

## Verification
The assertions take for granted that a commit never coincides with a squash or with a running walk, that no new squash arrives while `busy` is 1, and that sequence numbers grow with program order without wrapping. The stimulus keeps to this. It offers commit or squash only when its own model shows no walk in progress, chooses at most one of them per cycle, and hands out sequence numbers from one increasing counter. Squash points are drawn from between the oldest live entry and the newest issued number.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
    // Default geometry; NUM_PHYS - NUM_ARCH must be a power of two (log depth).
    localparam int unsigned DEF_ARCH  = 8;
    localparam int unsigned DEF_PHYS  = 16;
    localparam int unsigned DEF_WIDTH = 2;
    localparam int unsigned DEF_SEQ_W = 16;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

    // True when sequence number a is younger than b.
    function automatic logic seq_after(input logic [63:0] a, input logic [63:0] b);
        return a > b;
    endfunction
endpackage

// File: rtl/rn_freelist.sv
`timescale 1ns/1ps
module rn_freelist #(
    parameter int unsigned NP = 16,
    parameter int unsigned NA = 8,
    parameter int unsigned W  = 2,
    parameter int unsigned PW = $clog2(NP)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [W-1:0]          need,
    input  logic                  alloc_fire,
    input  logic                  rel_a_en,
    input  logic [PW-1:0]         rel_a,
    input  logic                  rel_b_en,
    input  logic [PW-1:0]         rel_b,
    output logic [W-1:0][PW-1:0]  grant,
    output logic [NP-1:0]         free_vec
);
    function automatic logic [NP-1:0] init_mask();
        logic [NP-1:0] m;
        for (int j = 0; j < int'(NP); j++) m[j] = (j >= int'(NA));
        return m;
    endfunction

    localparam logic [NP-1:0] FREE_INIT = init_mask();

    logic [NP-1:0] free_q, avail, take, nxt;

    // Lowest-index-first allocation, slot 0 served first.
    always_comb begin
        logic found;
        avail = free_q;
        take  = '0;
        for (int i = 0; i < int'(W); i++) begin
            grant[i] = '0;
            found    = 1'b0;
            if (need[i]) begin
                for (int j = 0; j < int'(NP); j++) begin
                    if (!found && avail[j]) begin
                        grant[i] = PW'(j);
                        avail[j] = 1'b0;
                        take[j]  = 1'b1;
                        found    = 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        nxt = free_q;
        if (alloc_fire) nxt = nxt & ~take;
        if (rel_a_en)   nxt[rel_a] = 1'b1;
        if (rel_b_en)   nxt[rel_b] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= FREE_INIT;
        else     free_q <= nxt;
    end

    assign free_vec = free_q;
endmodule

// File: rtl/rn_map.sv
`timescale 1ns/1ps
module rn_map #(
    parameter int unsigned NA = 8,
    parameter int unsigned NP = 16,
    parameter int unsigned W  = 2,
    parameter int unsigned AW = $clog2(NA),
    parameter int unsigned PW = $clog2(NP)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [W-1:0]          wr_en,
    input  logic [W-1:0][AW-1:0]  wr_arch,
    input  logic [W-1:0][PW-1:0]  wr_phys,
    input  logic                  undo_en,
    input  logic [AW-1:0]         undo_arch,
    input  logic [PW-1:0]         undo_phys,
    output logic [NA-1:0][PW-1:0] map_q
);
    // Later slots overwrite earlier ones on the same name.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < int'(NA); a++) map_q[a] <= PW'(a);
        end else begin
            for (int i = 0; i < int'(W); i++)
                if (wr_en[i]) map_q[wr_arch[i]] <= wr_phys[i];
            if (undo_en) map_q[undo_arch] <= undo_phys;
        end
    end
endmodule

// File: rtl/rn_hist.sv
`timescale 1ns/1ps
module rn_hist #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 2,
    parameter int unsigned SW    = 16,
    parameter int unsigned AW    = 3,
    parameter int unsigned PW    = 4,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [W-1:0]          push_en,
    input  logic [W-1:0][SW-1:0]  push_seq,
    input  logic [W-1:0][AW-1:0]  push_arch,
    input  logic [W-1:0][PW-1:0]  push_newp,
    input  logic [W-1:0][PW-1:0]  push_oldp,
    input  logic                  pop_head,
    input  logic                  pop_tail,
    output logic [SW-1:0]         head_seq,
    output logic [PW-1:0]         head_oldp,
    output logic [SW-1:0]         tail_seq,
    output logic [AW-1:0]         tail_arch,
    output logic [PW-1:0]         tail_newp,
    output logic [PW-1:0]         tail_oldp,
    output logic [CW-1:0]         count
);
    localparam int unsigned IW = $clog2(DEPTH);

    typedef struct packed {
        logic [SW-1:0] seq;
        logic [AW-1:0] arch;
        logic [PW-1:0] newp;
        logic [PW-1:0] oldp;
    } rec_t;

    rec_t                 mem [DEPTH];
    logic [IW-1:0]        head_q, tail_q;
    logic [CW-1:0]        count_q, acc;
    logic [W-1:0][CW-1:0] off;
    rec_t                 hrec, trec;

    // Pushing slots are packed in slot order behind the current tail.
    always_comb begin
        acc = '0;
        for (int i = 0; i < int'(W); i++) begin
            off[i] = acc;
            acc    = acc + CW'(push_en[i]);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(W); i++)
            if (push_en[i])
                mem[tail_q + off[i][IW-1:0]] <= '{push_seq[i], push_arch[i], push_newp[i], push_oldp[i]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + IW'(pop_head);
            tail_q  <= tail_q + acc[IW-1:0] - IW'(pop_tail);
            count_q <= count_q + acc - CW'(pop_head) - CW'(pop_tail);
        end
    end

    assign hrec      = mem[head_q];
    assign trec      = mem[tail_q - IW'(1)];
    assign head_seq  = hrec.seq;
    assign head_oldp = hrec.oldp;
    assign tail_seq  = trec.seq;
    assign tail_arch = trec.arch;
    assign tail_newp = trec.newp;
    assign tail_oldp = trec.oldp;
    assign count     = count_q;
endmodule

// File: rtl/rn_rename.sv
`timescale 1ns/1ps
module rn_rename import rn_pkg::*; #(
    parameter int unsigned NUM_ARCH = DEF_ARCH,
    parameter int unsigned NUM_PHYS = DEF_PHYS,
    parameter int unsigned RN_WIDTH = DEF_WIDTH,
    parameter int unsigned SEQ_W    = DEF_SEQ_W,
    parameter int unsigned AW       = $clog2(NUM_ARCH),
    parameter int unsigned PW       = $clog2(NUM_PHYS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [RN_WIDTH-1:0]       in_valid,
    input  logic [RN_WIDTH-1:0]       in_has_dst,
    input  logic [RN_WIDTH*AW-1:0]    in_dst,
    input  logic [RN_WIDTH*AW-1:0]    in_src_a,
    input  logic [RN_WIDTH*AW-1:0]    in_src_b,
    input  logic [RN_WIDTH*SEQ_W-1:0] in_seq,
    output logic                      in_ready,
    input  logic                      commit_valid,
    input  logic [SEQ_W-1:0]          commit_seq,
    input  logic                      squash_valid,
    input  logic [SEQ_W-1:0]          squash_seq,
    output logic                      busy,
    output logic [RN_WIDTH-1:0]       out_valid,
    output logic [RN_WIDTH-1:0]       out_has_dst,
    output logic [RN_WIDTH*SEQ_W-1:0] out_seq,
    output logic [RN_WIDTH*PW-1:0]    out_src_a_p,
    output logic [RN_WIDTH*PW-1:0]    out_src_b_p,
    output logic [RN_WIDTH*PW-1:0]    out_dst_p
);
    localparam int unsigned DEPTH = NUM_PHYS - NUM_ARCH;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic [RN_WIDTH-1:0][AW-1:0]    s_dst, s_a, s_b;
    logic [RN_WIDTH-1:0][SEQ_W-1:0] s_seq;
    logic [RN_WIDTH-1:0]            need, commit_slots;
    logic [RN_WIDTH-1:0][PW-1:0]    grant, p_a, p_b, p_old;
    logic [NUM_ARCH-1:0][PW-1:0]    map_q;
    logic [NUM_PHYS-1:0]            fl_free;
    logic [SEQ_W-1:0]               head_seq, tail_seq, point_q;
    logic [PW-1:0]                  head_oldp, tail_newp, tail_oldp;
    logic [AW-1:0]                  tail_arch;
    logic [CW-1:0]                  hist_count;
    walk_state_e                    walk_q;
    logic                           enough, fire, undo, com_hit, walking;

    assign s_dst = in_dst;
    assign s_a   = in_src_a;
    assign s_b   = in_src_b;
    assign s_seq = in_seq;
    assign need  = in_valid & in_has_dst;

    assign walking  = (walk_q == WALK_RUN);
    assign enough   = $countones(fl_free) >= $countones(need);
    assign in_ready = !walking && !squash_valid && enough;
    assign fire     = in_ready && (|in_valid);
    assign commit_slots = need & {RN_WIDTH{fire}};
    assign busy     = walking;

    // Map lookup with bypass from earlier destinations of the same group.
    always_comb begin
        for (int i = 0; i < int'(RN_WIDTH); i++) begin
            p_a[i]   = map_q[s_a[i]];
            p_b[i]   = map_q[s_b[i]];
            p_old[i] = map_q[s_dst[i]];
            for (int k = 0; k < int'(RN_WIDTH); k++) begin
                if (k < i && need[k]) begin
                    if (s_dst[k] == s_a[i])   p_a[i]   = grant[k];
                    if (s_dst[k] == s_b[i])   p_b[i]   = grant[k];
                    if (s_dst[k] == s_dst[i]) p_old[i] = grant[k];
                end
            end
        end
    end

    assign com_hit = commit_valid && (hist_count != '0) && (head_seq == commit_seq);
    assign undo    = walking && (hist_count != '0) && seq_after(64'(tail_seq), 64'(point_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            walk_q  <= WALK_IDLE;
            point_q <= '0;
        end else if (squash_valid) begin
            walk_q  <= WALK_RUN;
            point_q <= squash_seq;
        end else if (walking && !undo) begin
            walk_q  <= WALK_IDLE;
        end
    end

    rn_freelist #(.NP(NUM_PHYS), .NA(NUM_ARCH), .W(RN_WIDTH), .PW(PW)) u_fl (
        .clk(clk), .rst(rst), .need(need), .alloc_fire(fire),
        .rel_a_en(com_hit), .rel_a(head_oldp),
        .rel_b_en(undo), .rel_b(tail_newp),
        .grant(grant), .free_vec(fl_free)
    );

    rn_map #(.NA(NUM_ARCH), .NP(NUM_PHYS), .W(RN_WIDTH), .AW(AW), .PW(PW)) u_map (
        .clk(clk), .rst(rst), .wr_en(commit_slots), .wr_arch(s_dst), .wr_phys(grant),
        .undo_en(undo), .undo_arch(tail_arch), .undo_phys(tail_oldp), .map_q(map_q)
    );

    rn_hist #(.DEPTH(DEPTH), .W(RN_WIDTH), .SW(SEQ_W), .AW(AW), .PW(PW), .CW(CW)) u_hist (
        .clk(clk), .rst(rst), .push_en(commit_slots), .push_seq(s_seq),
        .push_arch(s_dst), .push_newp(grant), .push_oldp(p_old),
        .pop_head(com_hit), .pop_tail(undo),
        .head_seq(head_seq), .head_oldp(head_oldp), .tail_seq(tail_seq),
        .tail_arch(tail_arch), .tail_newp(tail_newp), .tail_oldp(tail_oldp),
        .count(hist_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= '0;
            out_has_dst <= '0;
            out_seq     <= '0;
            out_src_a_p <= '0;
            out_src_b_p <= '0;
            out_dst_p   <= '0;
        end else begin
            out_valid   <= fire ? in_valid : '0;
            out_has_dst <= fire ? need : '0;
            out_seq     <= s_seq;
            out_src_a_p <= p_a;
            out_src_b_p <= p_b;
            out_dst_p   <= grant;
        end
    end
endmodule

// File: rtl/rn_rename_chk.sv
`timescale 1ns/1ps
module rn_rename_chk #(
    parameter int unsigned NP = 16,
    parameter int unsigned NA = 8,
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic          busy,
    input logic          squash_valid,
    input logic          commit_valid,
    input logic          out_any,
    input logic [NP-1:0] free_vec,
    input logic [CW-1:0] hist_count
);
    // R8
    busy_blocks_rename_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    // R8
    squash_starts_walk_chk: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> busy);

    // R8
    walk_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (hist_count <= $past(hist_count)));

    // R5
    stall_no_output_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> !out_any);

    // R10
    reg_conservation_chk: assert property (@(posedge clk) disable iff (rst)
        (32'($countones(free_vec)) + 32'(hist_count)) == 32'(NP - NA));

    // R7
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit_valid && (squash_valid || busy)));
endmodule

bind rn_rename rn_rename_chk #(.NP(NUM_PHYS), .NA(NUM_ARCH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .busy(busy),
    .squash_valid(squash_valid), .commit_valid(commit_valid),
    .out_any(|out_valid), .free_vec(fl_free), .hist_count(hist_count)
);

// File: tb/sim_rn_rename.sv
`timescale 1ns/1ps
module sim_rn_rename;
    localparam int NA = 8, NP = 16, W = 2, SW = 16, AW = 3, PW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [W-1:0]    in_valid = '0, in_has_dst = '0;
    logic [W*AW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [W*SW-1:0] in_seq = '0;
    logic            in_ready, busy;
    logic            commit_valid = 1'b0, squash_valid = 1'b0;
    logic [SW-1:0]   commit_seq = '0, squash_seq = '0;
    logic [W-1:0]    out_valid, out_has_dst;
    logic [W*SW-1:0] out_seq;
    logic [W*PW-1:0] out_src_a_p, out_src_b_p, out_dst_p;

    rn_rename u0 (.*);

    always #2 clk = ~clk;

    int mmap[NA];
    bit mfree[NP];
    int hseq[256], harch[256], hnew[256], hold[256];
    int hb = 0, he = 0, mpoint = 0, nextseq = 1;
    bit mwalk = 0;
    int checks = 0, fails = 0;

    function automatic void model_reset();
        for (int a = 0; a < NA; a++) mmap[a] = a;
        for (int j = 0; j < NP; j++) mfree[j] = (j >= NA);
        hb = 0; he = 0; mwalk = 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = '0; in_has_dst = '0; in_dst = '0; in_src_a = '0; in_src_b = '0;
        in_seq = '0; commit_valid = 0; squash_valid = 0; commit_seq = '0; squash_seq = '0;
    endtask

    task automatic put(int i, bit hd, int d, int a, int b);
        in_valid[i] = 1'b1;
        in_has_dst[i] = hd;
        in_dst[i*AW +: AW] = AW'(d);
        in_src_a[i*AW +: AW] = AW'(a);
        in_src_b[i*AW +: AW] = AW'(b);
        in_seq[i*SW +: SW] = SW'(nextseq);
        nextseq++;
    endtask

    function automatic int o_a(int i); return int'(out_src_a_p[i*PW +: PW]); endfunction
    function automatic int o_b(int i); return int'(out_src_b_p[i*PW +: PW]); endfunction
    function automatic int o_d(int i); return int'(out_dst_p[i*PW +: PW]); endfunction

    // One clock: inputs already driven at a negedge; predict, advance, compare.
    task automatic step();
        int want, nfree, idx;
        bit rdy;
        bit ev[W];
        int ea[W], eb[W], ed[W], es[W];
        bit eh[W];
        bit nf[NP];
        #1;
        want = 0; nfree = 0;
        for (int i = 0; i < W; i++) if (in_valid[i] && in_has_dst[i]) want++;
        for (int j = 0; j < NP; j++) if (mfree[j]) nfree++;
        rdy = !mwalk && !squash_valid && (nfree >= want);
        chk((mwalk || squash_valid) ? "R8" : "R5", "in_ready", int'(in_ready), int'(rdy));
        nf = mfree;
        for (int i = 0; i < W; i++) begin
            ev[i] = rdy && in_valid[i];
            eh[i] = ev[i] && in_has_dst[i];
            ea[i] = 0; eb[i] = 0; ed[i] = 0;
            es[i] = int'(in_seq[i*SW +: SW]);
            if (ev[i]) begin
                ea[i] = mmap[in_src_a[i*AW +: AW]];
                eb[i] = mmap[in_src_b[i*AW +: AW]];
                if (in_has_dst[i]) begin
                    ed[i] = -1;
                    for (int j = 0; j < NP; j++) if (ed[i] < 0 && nf[j]) ed[i] = j;
                    nf[ed[i]] = 0;
                    idx = he & 255;
                    hseq[idx]  = es[i];
                    harch[idx] = int'(in_dst[i*AW +: AW]);
                    hnew[idx]  = ed[i];
                    hold[idx]  = mmap[harch[idx]];
                    he++;
                    mmap[harch[idx]] = ed[i];
                end
            end
        end
        if (commit_valid && he > hb && hseq[hb & 255] == int'(commit_seq)) begin
            nf[hold[hb & 255]] = 1;
            hb++;
        end
        if (mwalk) begin
            idx = (he - 1) & 255;
            if (he > hb && hseq[idx] > mpoint) begin
                mmap[harch[idx]] = hold[idx];
                nf[hnew[idx]] = 1;
                he--;
            end else mwalk = 0;
        end
        if (squash_valid) begin
            mwalk = 1;
            mpoint = int'(squash_seq);
        end
        mfree = nf;
        @(negedge clk);
        chk("R8", "busy", int'(busy), int'(mwalk));
        for (int i = 0; i < W; i++) begin
            chk("R2", "out_valid", int'(out_valid[i]), int'(ev[i]));
            if (ev[i]) begin
                chk("R2", "src_a", o_a(i), ea[i]);
                chk("R2", "src_b", o_b(i), eb[i]);
                chk("R2", "seq", int'(out_seq[i*SW +: SW]), es[i]);
                chk("R6", "has_dst", int'(out_has_dst[i]), int'(eh[i]));
                if (eh[i]) chk("R3", "dst", o_d(i), ed[i]);
            end
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R1", "in_ready after reset", int'(in_ready), 1);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        @(negedge clk);

        // Identity map, allocation order and in-group bypass
        idle(); put(0, 1, 1, 3, 5); put(1, 1, 1, 1, 1); step();
        chk("R1", "identity src_a", o_a(0), 3);
        chk("R1", "identity src_b", o_b(0), 5);
        chk("R3", "slot0 lowest free", o_d(0), 8);
        chk("R4", "bypass src_a", o_a(1), 8);
        chk("R4", "bypass src_b", o_b(1), 8);
        chk("R3", "slot1 next free", o_d(1), 9);

        // Slot without destination allocates nothing
        idle(); put(0, 0, 0, 1, 1); put(1, 1, 2, 0, 0); step();
        chk("R6", "no-dest slot src", o_a(0), 9);
        chk("R6", "next slot gets lowest", o_d(1), 10);

        // Drain the pool, then stall
        idle(); put(0, 1, 3, 0, 0); put(1, 1, 4, 0, 0); step();
        idle(); put(0, 1, 5, 0, 0); put(1, 1, 6, 0, 0); step();
        idle(); put(0, 1, 1, 0, 0); put(1, 1, 2, 0, 0); step();
        chk("R5", "stalled group dropped", int'(out_valid), 0);
        idle(); put(0, 1, 7, 0, 0); step();
        chk("R3", "last free register", o_d(0), 15);

        // Commit frees, mismatched commit ignored
        idle(); commit_valid = 1; commit_seq = 16'd1; step();
        idle(); put(0, 1, 0, 0, 0); step();
        chk("R10", "freed reg accepted", int'(out_valid[0]), 1);
        chk("R10", "freed reg reused", o_d(0), 1);
        idle(); commit_valid = 1; commit_seq = 16'd3; step();
        idle(); put(0, 1, 0, 0, 0); step();
        chk("R7", "mismatched commit frees nothing", int'(out_valid), 0);

        // Squash back to sequence 4
        idle(); squash_valid = 1; squash_seq = 16'd4; step();
        chk("R8", "busy after squash", int'(busy), 1);
        for (int g = 0; g < 40 && mwalk; g++) begin idle(); step(); end
        idle(); put(0, 1, 6, 3, 0); put(1, 0, 0, 1, 2); step();
        chk("R9", "restored arch3", o_a(0), 3);
        chk("R9", "restored arch0", o_b(0), 0);
        chk("R9", "kept arch1", o_a(1), 9);
        chk("R9", "kept arch2", o_b(1), 10);

        // Constrained random traffic
        for (int c = 0; c < 3000; c++) begin
            int r, lo;
            idle();
            for (int i = 0; i < W; i++)
                if ($urandom % 10 < 7)
                    put(i, ($urandom % 10) < 7, int'($urandom % NA), int'($urandom % NA), int'($urandom % NA));
            if (!mwalk) begin
                r = int'($urandom % 20);
                if (r == 0 && he > hb) begin
                    lo = hseq[hb & 255] - 1;
                    squash_valid = 1;
                    squash_seq = SW'(lo + int'($urandom % 32'(nextseq - lo)));
                end else if (r < 8 && he > hb) begin
                    commit_valid = 1;
                    commit_seq = (r < 7) ? SW'(hseq[hb & 255]) : SW'($urandom);
                end
            end
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule